// File: doc/BRIEF.md
# Prescaled Four-Channel Match Timer

A 32-bit free-running timer for a register bus. A prescale counter steps once on every clock while counting is enabled. When it reaches the programmed prescale limit it returns to zero, and the main count register advances by one. This event is called a tick. On every tick the current count is compared with four compare registers. A channel whose compare value equals the count at that tick is said to hit. A hit can set an interrupt flag, restart the count from zero, or halt counting. These three actions are chosen independently for each channel. Each channel also drives one output pin, which a hit can leave alone, drive low, drive high or toggle.

Software reaches the block through a plain synchronous bus: byte address, write strobe, write data and combinational read data. The interrupt request is the OR of the pending flags. Typical uses are periodic interrupts (interrupt plus restart), one-shot delays (stop) and square or PWM-like waveforms on the output pins.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, every output pin is low and the interrupt request is low.
- R2: The registers sit at these byte offsets:
  - 0x00: flags.
  - 0x04: control.
  - 0x08: count.
  - 0x0C: prescale limit.
  - 0x10: prescale counter.
  - 0x14: action control.
  - 0x18, 0x1C, 0x20, 0x24: compare registers 0 to 3.
  - 0x3C: output register.

  The prescale limit and the compare registers read back all 32 bits. The action control register keeps bits 11:0, the output register keeps bits 11:0, and the control register keeps bits 1:0. Any other address reads 0.
- R3: While control bit 0 is 1 and control bit 1 is 0, the prescale counter increases by one on each clock. In the clock where it equals the prescale limit it goes to 0 instead, and the count increases by one. When control bit 0 is 0, both counters hold.
- R4: While control bit 1 is 1, the count and the prescale counter are held at 0, and no tick occurs.
- R5: If channel n hits on a tick and action control bit 3n is 1, flag bit n becomes 1.
- R6: If channel n hits on a tick and action control bit 3n+1 is 1, the count becomes 0 instead of being incremented.
- R7: If channel n hits on a tick and action control bit 3n+2 is 1, control bit 0 is cleared. If no channel restarts the count on that tick, the count holds at the compare value.
- R8: Output register bits 3:0 are the levels of the pins match_o[3:0]. Bits 5+2n:4+2n hold the action for channel n: 0 keeps the level, 1 drives it low, 2 drives it high, 3 toggles it. The action is applied on each hit of that channel. A write to the output register loads the levels directly.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: irq_o is high exactly when at least one flag bit is 1.
- R11: When several channels hit on the same tick, all of their actions take effect together. If one channel restarts the count and another stops it, the count becomes 0 and counting is disabled.
- R12: A write to the count register or the prescale counter loads it directly. Counting continues from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe; the write takes effect at the clock edge |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| match_o | output | N_MATCH | Output pin levels |
| irq_o | output | 1 | Interrupt request, the OR of all flags |

## Verification
The hardest situation to reach is a tick on which several channels hit with different actions. One channel restarts the count, another halts it and a third toggles its pin. The stimulus reaches this by loading the same compare value into three channels with a prescale limit of zero, so all three hits land on one known tick.

A second sweep runs every channel with every output action across several prescale limits and compare values. Each run lasts a fixed number of enabled clocks. The expected count, flag and pin level are then derived from the number of ticks and the number of hits. Toggle parity is checked on both odd and even hit counts.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int OFF_FLAGS = 'h00;
  localparam int OFF_CTRL  = 'h04;
  localparam int OFF_COUNT = 'h08;
  localparam int OFF_PSCL  = 'h0C;
  localparam int OFF_PCNT  = 'h10;
  localparam int OFF_MCTL  = 'h14;
  localparam int OFF_CMP0  = 'h18;
  localparam int OFF_OUT   = 'h3C;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } out_act_e;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] pc_o,
  output logic         tick_o
);
  logic [W-1:0] pc_q;
  logic         at_limit;

  assign at_limit = (pc_q == limit_i);
  assign tick_o   = en_i && !clr_i && at_limit;
  assign pc_o     = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (load_i) pc_q <= load_val_i;
    else if (en_i)   pc_q <= at_limit ? '0 : pc_q + 1'b1;
  end

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !load_i |=> (pc_q == '0) || (pc_q == $past(pc_q) + 1'b1)); // R3
  AST_PC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i && !load_i |=> $stable(pc_q)); // R3
  AST_PC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pc_q == '0); // R4
endmodule

// File: rtl/tmr_match_ch.sv
`timescale 1ns/1ps
module tmr_match_ch
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] cmp_i,
  input  out_act_e     act_i,
  input  logic         load_i,
  input  logic         load_lvl_i,
  output logic         hit_o,
  output logic         lvl_o
);
  logic lvl_q;

  assign hit_o = tick_i && (count_i == cmp_i);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= 1'b0;
    else if (load_i) lvl_q <= load_lvl_i;
    else if (hit_o) begin
      unique case (act_i)
        ACT_LOW:  lvl_q <= 1'b0;
        ACT_HIGH: lvl_q <= 1'b1;
        ACT_FLIP: lvl_q <= ~lvl_q;
        default:  lvl_q <= lvl_q;
      endcase
    end
  end

  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o && !load_i |=> $stable(lvl_q)); // R8
  AST_LVL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !load_i && act_i == ACT_FLIP |=> lvl_q != $past(lvl_q)); // R8
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_MATCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_MATCH-1:0] match_o,
  output logic              irq_o
);
  localparam int MCTL_W   = 3 * N_MATCH;
  localparam int ACT_BASE = N_MATCH;
  localparam int ACT_W    = 2 * N_MATCH;

  function automatic logic is_addr(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic                ctrl_en_q, ctrl_rst_q;
  logic [DATA_W-1:0]   tc_q, pr_q, pc;
  logic [MCTL_W-1:0]   mctl_q;
  logic [ACT_W-1:0]    act_q;
  logic [N_MATCH-1:0]  flags_q;
  logic [DATA_W-1:0]   cmp_q [N_MATCH];

  logic wr_flags, wr_ctrl, wr_count, wr_pscl, wr_pcnt, wr_mctl, wr_out;
  logic [N_MATCH-1:0] wr_cmp, hit, int_en, rst_en, stop_en, int_hits, clr_mask, keep;
  logic tick, any_rst, any_stop;

  assign wr_flags = we_i && is_addr(addr_i, OFF_FLAGS);
  assign wr_ctrl  = we_i && is_addr(addr_i, OFF_CTRL);
  assign wr_count = we_i && is_addr(addr_i, OFF_COUNT);
  assign wr_pscl  = we_i && is_addr(addr_i, OFF_PSCL);
  assign wr_pcnt  = we_i && is_addr(addr_i, OFF_PCNT);
  assign wr_mctl  = we_i && is_addr(addr_i, OFF_MCTL);
  assign wr_out   = we_i && is_addr(addr_i, OFF_OUT);

  tmr_prescale #(.W(DATA_W)) u_pscl (
    .clk_i, .rst_ni,
    .en_i(ctrl_en_q), .clr_i(ctrl_rst_q), .limit_i(pr_q),
    .load_i(wr_pcnt), .load_val_i(wdata_i),
    .pc_o(pc), .tick_o(tick)
  );

  for (genvar g = 0; g < N_MATCH; g++) begin : g_ch
    assign wr_cmp[g]  = we_i && is_addr(addr_i, OFF_CMP0 + 4 * g);
    assign int_en[g]  = mctl_q[3*g];
    assign rst_en[g]  = mctl_q[3*g+1];
    assign stop_en[g] = mctl_q[3*g+2];
    tmr_match_ch #(.W(DATA_W)) u_ch (
      .clk_i, .rst_ni,
      .tick_i(tick), .count_i(tc_q), .cmp_i(cmp_q[g]),
      .act_i(out_act_e'(act_q[2*g +: 2])),
      .load_i(wr_out), .load_lvl_i(wdata_i[g]),
      .hit_o(hit[g]), .lvl_o(match_o[g])
    );
  end

  assign any_rst  = |(hit & rst_en);
  assign any_stop = |(hit & stop_en);
  assign int_hits = hit & int_en;
  assign clr_mask = wr_flags ? wdata_i[N_MATCH-1:0] : '0;
  assign keep     = flags_q & ~clr_mask;
  assign irq_o    = |flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_rst_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en_q  <= wdata_i[0];
      ctrl_rst_q <= wdata_i[1];
    end else if (any_stop) begin
      ctrl_en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tc_q <= '0;
    else if (ctrl_rst_q) tc_q <= '0;
    else if (wr_count)   tc_q <= wdata_i;
    else if (tick) begin
      if (any_rst)       tc_q <= '0;
      else if (!any_stop) tc_q <= tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q    <= '0;
      mctl_q  <= '0;
      act_q   <= '0;
      flags_q <= '0;
      for (int n = 0; n < N_MATCH; n++) cmp_q[n] <= '0;
    end else begin
      if (wr_pscl) pr_q   <= wdata_i;
      if (wr_mctl) mctl_q <= wdata_i[MCTL_W-1:0];
      if (wr_out)  act_q  <= wdata_i[ACT_BASE +: ACT_W];
      flags_q <= keep | int_hits;  // a new hit wins over a clear
      for (int n = 0; n < N_MATCH; n++)
        if (wr_cmp[n]) cmp_q[n] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_addr(addr_i, OFF_FLAGS)) rdata_o = DATA_W'(flags_q);
    if (is_addr(addr_i, OFF_CTRL))  rdata_o = DATA_W'({ctrl_rst_q, ctrl_en_q});
    if (is_addr(addr_i, OFF_COUNT)) rdata_o = tc_q;
    if (is_addr(addr_i, OFF_PSCL))  rdata_o = pr_q;
    if (is_addr(addr_i, OFF_PCNT))  rdata_o = pc;
    if (is_addr(addr_i, OFF_MCTL))  rdata_o = DATA_W'(mctl_q);
    if (is_addr(addr_i, OFF_OUT))   rdata_o = DATA_W'({act_q, match_o});
    for (int n = 0; n < N_MATCH; n++)
      if (is_addr(addr_i, OFF_CMP0 + 4 * n)) rdata_o = cmp_q[n];
  end

  AST_TC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !any_rst && !any_stop && !wr_count && !ctrl_rst_q |=> tc_q == $past(tc_q) + 1'b1); // R3
  AST_TC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_q |=> tc_q == '0); // R4
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |int_hits |=> (flags_q & $past(int_hits)) == $past(int_hits)); // R5
  AST_TC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst && !wr_count && !ctrl_rst_q |=> tc_q == '0); // R6
  AST_STOP_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stop && !wr_ctrl |=> !ctrl_en_q); // R7
  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |keep |=> (flags_q & $past(keep)) == $past(keep)); // R9
  AST_MULTI_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst && any_stop && !wr_count && !wr_ctrl && !ctrl_rst_q |=> tc_q == '0 && !ctrl_en_q); // R11
endmodule

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
  localparam logic [7:0] A_FLAGS = 8'h00, A_CTRL = 8'h04, A_COUNT = 8'h08, A_PSCL = 8'h0C,
                         A_PCNT = 8'h10, A_MCTL = 8'h14, A_CMP0 = 8'h18, A_OUT = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  match;
  logic        irq;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  match_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .match_o(match), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // exactly k enabled clock edges
  task automatic run(input int k);
    wr(A_CTRL, 32'h1);
    idle(k - 1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic restart();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
    wr(A_FLAGS, 32'hF);
    wr(A_MCTL, 32'h0);
    wr(A_OUT, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 'h3C; a += 4) begin
      rd(8'(a), v);
      chk($sformatf("R1 reg 0x%0h", a), v, 32'h0);
    end
    chk("R1 match_o", {28'h0, match}, 32'h0);
    chk("R1 irq_o", {31'h0, irq}, 32'h0);

    // R2: readback and masking
    wr(A_PSCL, 32'hDEADBEEF); rd(A_PSCL, v); chk("R2 prescale", v, 32'hDEADBEEF);
    wr(A_MCTL, 32'hFFFFFFFF); rd(A_MCTL, v); chk("R2 action ctl", v, 32'h0000_0FFF);
    wr(A_OUT, 32'hFFFFFFFF);  rd(A_OUT, v);  chk("R2 output reg", v, 32'h0000_0FFF);
    chk("R8 pins follow output write", {28'h0, match}, 32'hF);
    wr(A_CTRL, 32'hFFFFFFFE); rd(A_CTRL, v); chk("R2 control", v, 32'h2);
    for (int n = 0; n < 4; n++) begin
      wr(8'(A_CMP0 + 4 * n), 32'h1357_0000 + n * 32'h0101);
      rd(8'(A_CMP0 + 4 * n), v);
      chk($sformatf("R2 compare %0d", n), v, 32'h1357_0000 + n * 32'h0101);
    end
    rd(8'h40, v); chk("R2 unmapped", v, 32'h0);
    restart();

    // R4: held reset
    wr(A_PSCL, 32'h0);
    wr(A_COUNT, 32'd9);
    wr(A_CTRL, 32'h3);
    idle(6);
    rd(A_COUNT, v); chk("R4 count held", v, 32'h0);
    rd(A_PCNT, v);  chk("R4 prescale held", v, 32'h0);
    restart();

    // R3: prescaler sweep
    for (int p = 0; p < 4; p++) begin
      for (int ki = 0; ki < 4; ki++) begin
        int k;
        k = 1 + ki * 5;
        restart();
        wr(A_PSCL, p);
        run(k);
        rd(A_COUNT, v); chk($sformatf("R3 count p=%0d k=%0d", p, k), v, k / (p + 1));
        rd(A_PCNT, v);  chk($sformatf("R3 prescale p=%0d k=%0d", p, k), v, k % (p + 1));
        idle(3);
        rd(A_COUNT, v); chk($sformatf("R3 hold when off p=%0d", p), v, k / (p + 1));
      end
    end

    // R12: direct loads
    restart();
    wr(A_PSCL, 32'd2);
    wr(A_COUNT, 32'd100);
    wr(A_PCNT, 32'd1);
    rd(A_COUNT, v); chk("R12 count load", v, 32'd100);
    rd(A_PCNT, v);  chk("R12 prescale load", v, 32'd1);
    run(7);
    rd(A_COUNT, v); chk("R12 count continues", v, 32'd102);
    rd(A_PCNT, v);  chk("R12 prescale continues", v, 32'd2);

    // R5 R6 R8 R9 R10: restart channel with each output action
    for (int n = 0; n < 4; n++) begin
      for (int a = 0; a < 4; a++) begin
        for (int mi = 0; mi < 2; mi++) begin
          for (int p = 0; p < 2; p++) begin
            int m, k, ticks, hits;
            logic init, lvl;
            m = mi * 2;
            k = 11 + n;
            init = 1'(n ^ a);
            ticks = k / (p + 1);
            hits = ticks / (m + 1);
            restart();
            for (int c = 0; c < 4; c++) wr(8'(A_CMP0 + 4 * c), 32'hFFFF_0000);
            wr(A_CMP0 + 8'(4 * n), m);
            wr(A_PSCL, p);
            wr(A_OUT, (a << (4 + 2 * n)) | (32'(init) << n));
            wr(A_MCTL, 32'b011 << (3 * n));
            run(k);
            case (a)
              1: lvl = (hits > 0) ? 1'b0 : init;
              2: lvl = (hits > 0) ? 1'b1 : init;
              3: lvl = init ^ 1'(hits & 1);
              default: lvl = init;
            endcase
            rd(A_COUNT, v);
            chk($sformatf("R6 count ch%0d m=%0d p=%0d", n, m, p), v, ticks % (m + 1));
            rd(A_FLAGS, v);
            chk($sformatf("R5 flag ch%0d m=%0d p=%0d", n, m, p), v, (hits > 0) ? (32'h1 << n) : 32'h0);
            chk($sformatf("R10 irq ch%0d", n), {31'h0, irq}, (hits > 0) ? 32'h1 : 32'h0);
            chk($sformatf("R8 pin ch%0d act=%0d hits=%0d", n, a, hits), {31'h0, match[n]}, {31'h0, lvl});
            rd(A_OUT, v);
            chk($sformatf("R8 level reg ch%0d", n), {31'h0, v[n]}, {31'h0, lvl});
            if (hits > 0) begin
              wr(A_FLAGS, 32'h0);
              rd(A_FLAGS, v); chk("R9 write 0 keeps flag", v, 32'h1 << n);
              wr(A_FLAGS, ~(32'h1 << n));
              rd(A_FLAGS, v); chk("R9 other bits keep flag", v, 32'h1 << n);
              wr(A_FLAGS, 32'h1 << n);
              rd(A_FLAGS, v); chk("R9 write 1 clears", v, 32'h0);
              chk("R10 irq drops", {31'h0, irq}, 32'h0);
            end
          end
        end
      end
    end

    // R7: stop action
    for (int n = 0; n < 4; n++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int p = 0; p < 3; p += 2) begin
          int m;
          m = 1 + 2 * mi;
          restart();
          for (int c = 0; c < 4; c++) wr(8'(A_CMP0 + 4 * c), 32'hFFFF_0000);
          wr(A_CMP0 + 8'(4 * n), m);
          wr(A_PSCL, p);
          wr(A_MCTL, 32'b100 << (3 * n));
          wr(A_CTRL, 32'h1);
          idle(30);
          rd(A_COUNT, v); chk($sformatf("R7 count ch%0d m=%0d p=%0d", n, m, p), v, m);
          rd(A_CTRL, v);  chk($sformatf("R7 enable cleared ch%0d", n), v, 32'h0);
          rd(A_PCNT, v);  chk($sformatf("R7 prescale ch%0d", n), v, 32'h0);
          rd(A_FLAGS, v); chk($sformatf("R5 no flag without int ch%0d", n), v, 32'h0);
        end
      end
    end

    // R11: simultaneous hits
    restart();
    wr(A_PSCL, 32'h0);
    for (int c = 0; c < 3; c++) wr(8'(A_CMP0 + 4 * c), 32'd3);
    wr(A_CMP0 + 8'd12, 32'hFFFF_0000);
    wr(A_OUT, (32'd2 << 4) | (32'd3 << 8));
    wr(A_MCTL, 32'b011 | (32'b100 << 3) | (32'b001 << 6));
    wr(A_CTRL, 32'h1);
    idle(10);
    rd(A_COUNT, v); chk("R11 count restarted", v, 32'h0);
    rd(A_CTRL, v);  chk("R11 stopped", v, 32'h0);
    rd(A_FLAGS, v); chk("R11 flags", v, 32'h5);
    chk("R11 pins", {28'h0, match}, 32'h5);
    chk("R10 irq multi", {31'h0, irq}, 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule